// File: doc/BRIEF.md
# Serial Memory Read Responder

This block listens on an asynchronous serial receive line for fixed-size read requests and answers each one by streaming bytes out of an attached byte-addressed memory on its serial transmit line. A request is sixteen bytes long. It carries four 32-bit little-endian words: a command code, a storage selector, a starting byte address and a byte count. Only the read command code is acted on. The reply is the raw memory contents starting at the requested address, with no header, trailer or padding.

Inside, a 16x oversampling receiver turns the line into bytes. An assembler gathers sixteen of them, checks the command word and hands the address and count to a sequencer. The sequencer reads the memory one byte per synchronous read and passes each byte to the transmitter. One free-running oversampling tick, set by a divisor parameter, times both directions. The assembler throws away partial requests after a framing error or after a long silence. It also ignores traffic while a reply is still going out.

Top module: `uart_rd_responder`

## Requirements
- R1: Both lines use 8 data bits sent least significant bit first, no parity and one stop bit. The line idles at 1 and the start bit is 0. Every bit lasts 16 ticks, and one tick is OS_DIV clock cycles (9600 baud at 100 MHz with the default divisor).
- R2: A request is 16 bytes. It holds four 32-bit words, each sent least significant byte first: command, storage selector (bytes 4-7, ignored), start address (bytes 8-11) and count (bytes 12-15). When the 16th byte arrives and the command word equals 0x0000002C, the block starts a reply.
- R3: A reply is exactly the clamped count of bytes. Byte k of the reply is the memory byte at address start+k, sent in ascending address order with nothing added.
- R4: Each memory read is a one-cycle pulse on mem_rd_en with the address on mem_addr. The block takes mem_rd_data on the next clock edge and transmits it.
- R5: A request whose command word is not 0x2C produces no output and no memory read. The byte that follows it is treated as byte 0 of a new request.
- R6: The memory is MEM_BYTES bytes (128 KB by default). Bytes at addresses at or above MEM_BYTES are not sent. A start address at or beyond the end produces no reply.
- R7: A low pulse on the receive line that has ended by mid-start-bit is treated as a false start and produces no byte.
- R8: A byte whose stop bit samples as 0 raises frame_err for one cycle. Any partly assembled request is then discarded, and the block waits for the line to return high before it looks for a new start bit.
- R9: If GAP_BITS bit times pass between completed bytes in the middle of a request, the partial request is discarded.
- R10: Bytes that complete before the last stop bit of the current reply has been sent are discarded.
- R11: After reset txd is 1, mem_rd_en is 0 and frame_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line, idles high |
| mem_rd_en | output | 1 | Memory read strobe, one cycle per byte |
| mem_addr | output | ADDR_W (17) | Memory byte address |
| mem_rd_data | input | 8 | Memory read data, valid the cycle after mem_rd_en |
| frame_err | output | 1 | One-cycle pulse for a received byte with a bad stop bit |

## Verification
The reply to a request cannot start until the sixteenth request byte has been accepted at the middle of its stop bit. After that, one cycle passes before the request is raised and one more before the read. The transmitter launches the cycle after that, and its first bit is aligned to the next tick. Each reply bit then lasts exactly 16 ticks. Because the exact start cycle can vary by a few cycles, the scoreboard monitor does not wait for fixed cycles. It finds each start edge on txd and then samples in the middle of every bit, 32 clocks apart at the bench divisor. The driver pushes each expected byte into a queue when it sends a request, and the monitor pops one per received frame. A byte that arrives with an empty queue is reported as a failure. At the end of each scenario, once the longest possible reply has had time to finish, a separate check confirms that nothing is still expected.

// File: rtl/uart_rd_pkg.sv
package uart_rd_pkg;

  localparam int          REQ_BYTES = 16;
  localparam logic [31:0] OP_READ   = 32'h0000_002C;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
  } rx_state_t;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_READ, SQ_LAUNCH, SQ_DRAIN
  } seq_state_t;

  // Extract little-endian word idx from a 16-byte request image (byte 0 in [7:0]).
  function automatic logic [31:0] le_word(input logic [127:0] img, input int idx);
    return img[idx*32 +: 32];
  endfunction

  // Number of bytes that may actually be sent for a request of cnt bytes at off.
  function automatic logic [31:0] clamp_count(input logic [31:0] off,
                                              input logic [31:0] cnt,
                                              input logic [32:0] limit);
    logic [32:0] room;
    if ({1'b0, off} >= limit) return '0;
    room = limit - {1'b0, off};
    if ({1'b0, cnt} > room) return room[31:0];
    return cnt;
  endfunction

endpackage

// File: rtl/urr_rx.sv
module urr_rx
  import uart_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd_s,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_err
);

  rx_state_t  state;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] shreg;

  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rxd_s) begin
            state <= RX_START;
            tcnt  <= '0;
          end
        end
        RX_START: begin
          if (os_tick) begin
            if (tcnt == 4'd7) begin
              // mid start bit: high again means a glitch
              if (rxd_s) state <= RX_IDLE;
              else begin
                state <= RX_DATA;
                tcnt  <= '0;
                bidx  <= '0;
              end
            end else tcnt <= tcnt + 4'd1;
          end
        end
        RX_DATA: begin
          if (os_tick) begin
            if (tcnt == 4'd15) begin
              shreg <= {rxd_s, shreg[7:1]};
              tcnt  <= '0;
              if (bidx == 3'd7) state <= RX_STOP;
              else bidx <= bidx + 3'd1;
            end else tcnt <= tcnt + 4'd1;
          end
        end
        RX_STOP: begin
          if (os_tick) begin
            if (tcnt == 4'd15) begin
              tcnt <= '0;
              if (rxd_s) begin
                byte_valid <= 1'b1;
                state      <= RX_IDLE;
              end else begin
                frame_err <= 1'b1;
                state     <= RX_BREAK;
              end
            end else tcnt <= tcnt + 4'd1;
          end
        end
        RX_BREAK: begin
          if (rxd_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/urr_tx.sv
module urr_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       start,
  input  logic [7:0] data,
  output logic       txd,
  output logic       idle
);

  logic [9:0] shreg;
  logic [3:0] bits_left;
  logic [3:0] tcnt;
  logic       active;

  assign idle = !active;

  always_comb begin
    txd = active ? shreg[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      active    <= 1'b0;
    end else if (!active) begin
      if (start) begin
        shreg     <= {1'b1, data, 1'b0};
        bits_left <= 4'd10;
        tcnt      <= '0;
        active    <= 1'b1;
      end
    end else if (os_tick) begin
      if (tcnt == 4'd15) begin
        tcnt      <= '0;
        shreg     <= {1'b1, shreg[9:1]};
        bits_left <= bits_left - 4'd1;
        if (bits_left == 4'd1) active <= 1'b0;
      end else tcnt <= tcnt + 4'd1;
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);  // R10

endmodule

// File: rtl/urr_assembler.sv
module urr_assembler
  import uart_rd_pkg::*;
#(
  parameter int GAP_BITS = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        frame_err,
  input  logic        busy,
  output logic        req_valid,
  output logic [31:0] req_off,
  output logic [31:0] req_cnt
);

  localparam int GAP_TICKS = GAP_BITS * 16;
  localparam int GW        = $clog2(GAP_TICKS + 1);

  logic [3:0]    idx;
  logic [119:0]  held;
  logic [GW-1:0] gap_cnt;
  logic [127:0]  full;
  logic          take;
  logic          gap_expire;

  assign full       = {byte_data, held};
  assign take       = byte_valid && !busy && !req_valid;
  assign gap_expire = (idx != 4'd0) && os_tick && (gap_cnt == GW'(GAP_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      held      <= '0;
      gap_cnt   <= '0;
      req_valid <= 1'b0;
      req_off   <= '0;
      req_cnt   <= '0;
    end else begin
      req_valid <= 1'b0;
      if (frame_err) begin
        idx     <= '0;
        gap_cnt <= '0;
      end else if (take) begin
        gap_cnt <= '0;
        if (idx == 4'(REQ_BYTES - 1)) begin
          idx <= '0;
          if (le_word(full, 0) == OP_READ) begin
            req_valid <= 1'b1;
            req_off   <= le_word(full, 2);
            req_cnt   <= le_word(full, 3);
          end
        end else begin
          held <= {byte_data, held[119:8]};
          idx  <= idx + 4'd1;
        end
      end else if (gap_expire) begin
        idx     <= '0;
        gap_cnt <= '0;
      end else if (idx != 4'd0 && os_tick) begin
        gap_cnt <= gap_cnt + GW'(1);
      end
    end
  end

  AST_FRAME_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (idx == 4'd0));  // R8
  AST_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_expire && !byte_valid) |=> (idx == 4'd0));  // R9
  AST_REQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(byte_valid));  // R2

endmodule

// File: rtl/urr_sequencer.sv
module urr_sequencer
  import uart_rd_pkg::*;
#(
  parameter int MEM_BYTES = 131072,
  parameter int ADDR_W    = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_off,
  input  logic [31:0]       req_cnt,
  input  logic              tx_idle,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              tx_start,
  output logic [7:0]        tx_data,
  output logic              busy
);

  seq_state_t        state;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       remain;
  logic [31:0]       allowed;

  assign allowed   = clamp_count(req_off, req_cnt, 33'(MEM_BYTES));
  assign mem_addr  = addr;
  assign mem_rd_en = (state == SQ_READ) && (remain != 32'd0) && tx_idle;
  assign tx_start  = (state == SQ_LAUNCH);
  assign tx_data   = mem_rd_data;
  assign busy      = (state != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      addr   <= '0;
      remain <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            addr   <= req_off[ADDR_W-1:0];
            remain <= allowed;
            state  <= SQ_READ;
          end
        end
        SQ_READ: begin
          if (remain == 32'd0) state <= SQ_DRAIN;
          else if (tx_idle)    state <= SQ_LAUNCH;
        end
        SQ_LAUNCH: begin
          addr   <= addr + ADDR_W'(1);
          remain <= remain - 32'd1;
          state  <= SQ_READ;
        end
        SQ_DRAIN: begin
          if (tx_idle) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_LAUNCH_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(mem_rd_en));  // R4

endmodule

// File: rtl/uart_rd_responder.sv
module uart_rd_responder
  import uart_rd_pkg::*;
#(
  parameter int OS_DIV    = 651,
  parameter int MEM_BYTES = 131072,
  parameter int GAP_BITS  = 40,
  localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  output logic              txd,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              frame_err
);

  localparam int DIV_W = $clog2(OS_DIV + 1);

  logic [DIV_W-1:0] os_cnt;
  logic             os_tick;
  logic [1:0]       rx_sync;
  logic             rx_byte_valid;
  logic [7:0]       rx_byte;
  logic             req_valid;
  logic [31:0]      req_off;
  logic [31:0]      req_cnt;
  logic             seq_busy;
  logic             tx_start;
  logic [7:0]       tx_data;
  logic             tx_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_cnt  <= '0;
      os_tick <= 1'b0;
      rx_sync <= 2'b11;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      os_tick <= (os_cnt == DIV_W'(OS_DIV - 1));
      if (os_cnt == DIV_W'(OS_DIV - 1)) os_cnt <= '0;
      else                              os_cnt <= os_cnt + DIV_W'(1);
    end
  end

  urr_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .rxd_s      (rx_sync[1]),
    .byte_valid (rx_byte_valid),
    .byte_data  (rx_byte),
    .frame_err  (frame_err)
  );

  urr_assembler #(.GAP_BITS(GAP_BITS)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .byte_valid (rx_byte_valid),
    .byte_data  (rx_byte),
    .frame_err  (frame_err),
    .busy       (seq_busy),
    .req_valid  (req_valid),
    .req_off    (req_off),
    .req_cnt    (req_cnt)
  );

  urr_sequencer #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_off     (req_off),
    .req_cnt     (req_cnt),
    .tx_idle     (tx_idle),
    .mem_rd_data (mem_rd_data),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .tx_start    (tx_start),
    .tx_data     (tx_data),
    .busy        (seq_busy)
  );

  urr_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .os_tick (os_tick),
    .start   (tx_start),
    .data    (tx_data),
    .txd     (txd),
    .idle    (tx_idle)
  );

  AST_REQ_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !seq_busy);  // R10
  AST_READ_ONLY_WHEN_TX_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> tx_start);  // R4

endmodule

// File: tb/uart_rd_responder_tb.sv
module uart_rd_responder_tb;

  localparam int OS_DIV    = 2;
  localparam int MEM_BYTES = 131072;
  localparam int GAP_BITS  = 20;
  localparam int BIT       = 16 * OS_DIV;
  localparam int ADDR_W    = $clog2(MEM_BYTES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rxd = 1'b1;
  logic              txd;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rd_data = 8'h00;
  logic              frame_err;

  int n_checks = 0;
  int n_fail   = 0;
  int fe_seen  = 0;
  bit finished = 1'b0;
  string cur_tag = "R3";
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_rd_responder #(.OS_DIV(OS_DIV), .MEM_BYTES(MEM_BYTES), .GAP_BITS(GAP_BITS)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd         (rxd),
    .txd         (txd),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .frame_err   (frame_err)
  );

  function automatic logic [7:0] mem_fn(input longint a);
    return 8'(((a * 7) + (a >> 8) + 8'h35) & 8'hFF);
  endfunction

  // memory model: data one edge after the strobe (R4)
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_fn(longint'(mem_addr));

  always @(negedge clk) if (rst_n && frame_err) fe_seen++;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic send_req(input logic [31:0] op, input logic [31:0] id,
                          input logic [31:0] off, input logic [31:0] cnt,
                          input int nbytes, input bit expect_resp);
    logic [127:0] img;
    img = {cnt, off, id, op};
    if (expect_resp && op == 32'h2C) begin
      for (longint a = off; a < longint'(off) + longint'(cnt) && a < MEM_BYTES; a++)
        exp_q.push_back(mem_fn(a));
    end
    for (int i = 0; i < nbytes; i++) send_byte(img[i*8 +: 8], 1'b1);
  endtask

  task automatic wait_drain(input string tag);
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (12 * BIT) @(negedge clk);
    check(exp_q.size() == 0, tag, "reply bytes still missing", exp_q.size(), 0);
  endtask

  // monitor: decode txd frames and compare with the scoreboard
  initial begin
    logic [7:0] got;
    bit start_ok;
    bit stop_ok;
    logic [7:0] exp;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (BIT / 2) @(negedge clk);
        start_ok = (txd === 1'b0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        stop_ok = (txd === 1'b1);
        check(start_ok && stop_ok, "R1", "frame start/stop", {stop_ok, start_ok}, 2'b11);
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected reply byte", got, 0);
        end else begin
          exp = exp_q.pop_front();
          check(got == exp, cur_tag, "reply byte", got, exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int fe_before;
    repeat (5) @(negedge clk);
    // R11 reset state
    check(txd == 1'b1, "R11", "txd in reset", txd, 1);
    check(mem_rd_en == 1'b0, "R11", "mem_rd_en in reset", mem_rd_en, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(frame_err == 1'b0, "R11", "frame_err after reset", frame_err, 0);

    // R2/R3 basic reads
    cur_tag = "R2";
    send_req(32'h2C, 32'h0, 32'h100, 32'd4, 16, 1'b1);
    wait_drain("R2");
    cur_tag = "R3";
    send_req(32'h2C, 32'hA5A5_0001, 32'h1234, 32'd1, 16, 1'b1);
    wait_drain("R3");

    // R5 wrong opcode, then fresh request right behind it
    cur_tag = "R5";
    send_req(32'h2D, 32'h0, 32'h40, 32'd3, 16, 1'b0);
    send_req(32'h2C, 32'h0, 32'h7F0, 32'd3, 16, 1'b1);
    wait_drain("R5");

    // R6 clamp at end of memory and start beyond the end
    cur_tag = "R6";
    send_req(32'h2C, 32'h0, MEM_BYTES - 2, 32'd5, 16, 1'b1);
    wait_drain("R6");
    send_req(32'h2C, 32'h0, MEM_BYTES + 10, 32'd3, 16, 1'b1);
    wait_drain("R6");

    // R7 short glitch is not a byte
    cur_tag = "R7";
    fe_before = fe_seen;
    rxd = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    send_req(32'h2C, 32'h0, 32'h2000, 32'd2, 16, 1'b1);
    wait_drain("R7");
    check(fe_seen == fe_before, "R7", "no frame error from glitch", fe_seen, fe_before);

    // R8 framing error drops the partial request
    cur_tag = "R8";
    fe_before = fe_seen;
    send_req(32'h2C, 32'h0, 32'h3000, 32'd4, 5, 1'b0);
    send_byte(8'h55, 1'b0);
    repeat (2 * BIT) @(negedge clk);
    check(fe_seen == fe_before + 1, "R8", "frame_err pulses", fe_seen, fe_before + 1);
    send_req(32'h2C, 32'h0, 32'h3100, 32'd2, 16, 1'b1);
    wait_drain("R8");

    // R9 silence in mid request drops it
    cur_tag = "R9";
    send_req(32'h2C, 32'h0000_0707, 32'h4000, 32'd4, 7, 1'b0);
    repeat ((GAP_BITS + 10) * BIT) @(negedge clk);
    send_req(32'h2C, 32'h0000_0707, 32'h4400, 32'd2, 16, 1'b1);
    wait_drain("R9");

    // R10 a request sent during a long reply is discarded
    cur_tag = "R10";
    send_req(32'h2C, 32'h0, 32'h5000, 32'd20, 16, 1'b1);
    send_req(32'h2C, 32'h0, 32'h6000, 32'd2, 16, 1'b0);
    wait_drain("R10");
    send_req(32'h2C, 32'h0, 32'h6100, 32'd2, 16, 1'b1);
    wait_drain("R10");

    finish_run();
  end

endmodule